// File: doc/BRIEF.md
# Two-Mode Door Controller

This block decides, once per clock, whether a door is commanded shut or open. A mode input chooses between a hand-held manual mode and a sensor-driven automatic mode. In manual mode the door rests open and is held shut only while the push-button is kept down. In automatic mode the door rests shut. A rising edge of the button toggles it. A presence sensor forces it open and keeps it open. An internal timeout shuts an open door after a programmable number of idle cycles.

The button's rising edge is found inside the block, so the caller feeds the raw button level. A one-cycle indication marks the cycle in which the door command turns from open to shut, so that a motion emulator or display can start a closing sequence. Every output is registered.

Top module: `door_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `door_shut` = 0 (open) and `shut_start` = 0.
- R2: In manual mode (`auto_mode` = 0, also 0 in the previous cycle), `door_shut` after an edge equals the `push_btn` level sampled at that edge.
- R3: In automatic mode with `presence` = 0, a cycle where `push_btn` is 1 after being 0 in the previous cycle inverts `door_shut` at that edge. A button held high causes no further change.
- R4: In automatic mode, `presence` = 1 at an edge makes `door_shut` 0 after it. A button press while presence is high leaves the door open, and presence rising while the door is already open changes nothing.
- R5: In automatic mode, an open door with `presence` = 0 and no button press shuts after exactly TIMEOUT+1 consecutive such cycles, TIMEOUT being a parameter (default 15, giving a 4-bit counter).
- R6: The timeout count restarts from zero whenever the door is shut or `presence` is seen. After a presence cycle the full TIMEOUT+1 idle cycles are needed again.
- R7: The first cycle in manual mode after automatic mode forces `door_shut` to 0, even if `push_btn` is held.
- R8: `shut_start` is 1 for exactly the cycles in which `door_shut` has just turned from 0 to 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, opens the door |
| auto_mode | input | 1 | 1 = automatic mode, 0 = manual mode |
| push_btn | input | 1 | Raw push-button level |
| presence | input | 1 | Presence sensor, 1 = someone detected |
| door_shut | output | 1 | Door command, 1 = shut, 0 = open |
| shut_start | output | 1 | One-cycle mark that the door command just turned to shut |

## Verification
The hardest behaviour to reach from the ports is the timeout restart. The door must first be opened in automatic mode and then left idle for a long run of cycles. A single presence cycle must fall midway through that run, and the run must then be extended to exactly one cycle short of the limit and then to the limit itself. The stimulus reaches this by opening the door with a button edge and holding presence for a few cycles. It then idles partway, inserts one presence cycle, and steps through the full idle window, checking the door on every cycle. The mode-exit override is reached by shutting the door in automatic mode and dropping to manual with the button still held.

// File: rtl/door_pkg.sv
package door_pkg;
  typedef enum logic {
    MODE_MANUAL = 1'b0,
    MODE_AUTO   = 1'b1
  } door_mode_e;

  localparam int DEFAULT_TIMEOUT = 15;
endpackage

// File: rtl/door_edge.sv
module door_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/door_timer.sv
module door_timer #(
  parameter int TIMEOUT = 15,
  parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i)   cnt_q <= '0;
    else if (cnt_q == LIM) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LIM);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM); // R5
  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> cnt_q == '0); // R6
endmodule

// File: rtl/door_fsm.sv
module door_fsm
  import door_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic auto_i,
  input  logic btn_i,
  input  logic presence_i,
  input  logic rise_i,
  input  logic expire_i,
  output logic shut_o,
  output logic start_o
);
  door_mode_e mode_q;
  logic       shut_q;
  logic       start_q;
  logic       shut_d;

  always_comb begin
    shut_d = shut_q;
    if (!auto_i) begin
      if (mode_q == MODE_AUTO) shut_d = 1'b0;
      else                     shut_d = btn_i;
    end else if (presence_i) begin
      shut_d = 1'b0;
    end else if (rise_i || expire_i) begin
      shut_d = ~shut_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_MANUAL;
      shut_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      mode_q  <= auto_i ? MODE_AUTO : MODE_MANUAL;
      shut_q  <= shut_d;
      start_q <= shut_d & ~shut_q;
    end
  end

  assign shut_o  = shut_q;
  assign start_o = start_q;

  AST_RST_OPEN: assert property (@(posedge clk)
    rst |=> (!shut_q && !start_q)); // R1
  AST_MANUAL_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!auto_i && mode_q == MODE_MANUAL) |=> shut_q == $past(btn_i)); // R2
  AST_PRESENCE_OPEN: assert property (@(posedge clk) disable iff (rst)
    (auto_i && presence_i) |=> !shut_q); // R4
  AST_MODE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (!auto_i && mode_q == MODE_AUTO) |=> !shut_q); // R7
  AST_START_MARK: assert property (@(posedge clk) disable iff (rst)
    $rose(shut_q) |-> start_q); // R8
  AST_START_ONLY_RISE: assert property (@(posedge clk) disable iff (rst)
    start_q |-> shut_q); // R8
endmodule

// File: rtl/door_ctrl.sv
module door_ctrl #(
  parameter int TIMEOUT = door_pkg::DEFAULT_TIMEOUT,
  parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_mode,
  input  logic push_btn,
  input  logic presence,
  output logic door_shut,
  output logic shut_start
);
  logic rise;
  logic expire;
  logic run;
  logic shut_int;
  logic start_int;

  assign run = auto_mode & ~shut_int & ~presence;

  door_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (push_btn),
    .rise_o  (rise)
  );

  door_timer #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run),
    .expire_o (expire)
  );

  door_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .auto_i     (auto_mode),
    .btn_i      (push_btn),
    .presence_i (presence),
    .rise_i     (rise),
    .expire_i   (expire),
    .shut_o     (shut_int),
    .start_o    (start_int)
  );

  assign door_shut  = shut_int;
  assign shut_start = start_int;
endmodule

// File: tb/sim_door_ctrl.sv
module sim_door_ctrl;
  localparam int TO = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic auto_mode = 1'b0;
  logic push_btn = 1'b0;
  logic presence = 1'b0;
  logic door_shut;
  logic shut_start;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  door_ctrl #(.TIMEOUT(TO)) u0 (
    .clk(clk), .rst(rst), .auto_mode(auto_mode), .push_btn(push_btn),
    .presence(presence), .door_shut(door_shut), .shut_start(shut_start)
  );

  // Driver: apply one cycle of inputs and queue the outputs expected after that edge.
  task automatic step(input logic r, input logic a, input logic b, input logic p,
                      input logic es, input logic ec, input string tag);
    @(negedge clk);
    rst = r; auto_mode = a; push_btn = b; presence = p;
    exp_q.push_back({es, ec});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare shortly after each edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if ({door_shut, shut_start} !== e) begin
        n_bad++;
        $display("FAIL %s: shut/start actual %b%b expected %b%b", t,
                 door_shut, shut_start, e[1], e[0]);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset opens
    step(1, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 1, 0, 0, 0, "R1");
    // R2 manual level, R8 start mark
    step(0, 0, 1, 0, 1, 1, "R2/R8");
    step(0, 0, 1, 0, 1, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    // R3 automatic toggle on edge
    step(0, 1, 1, 0, 1, 1, "R3");
    step(0, 1, 1, 0, 1, 0, "R3 hold");
    step(0, 1, 0, 0, 1, 0, "R3");
    step(0, 1, 1, 0, 0, 0, "R3 open");
    step(0, 1, 0, 0, 0, 0, "R5 idle");
    // R4 presence holds open, press ignored
    step(0, 1, 0, 1, 0, 0, "R4");
    step(0, 1, 1, 1, 0, 0, "R4 press");
    step(0, 1, 0, 1, 0, 0, "R4");
    // R6 restart midway
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0, 0, "R6 idle");
    step(0, 1, 0, 1, 0, 0, "R6 presence");
    // R5 full window
    for (int i = 0; i < TO; i++) step(0, 1, 0, 0, 0, 0, "R5 before limit");
    step(0, 1, 0, 0, 1, 1, "R5 limit");
    step(0, 1, 0, 0, 1, 0, "R5 stays shut");
    // R4 presence opens shut door
    step(0, 1, 0, 1, 0, 0, "R4 open");
    // R7 mode exit
    step(0, 1, 1, 0, 1, 1, "R3");
    step(0, 0, 1, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 1, 1, "R2 after exit");
    step(0, 0, 1, 0, 1, 0, "R8 single");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule